// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block sits between a processor core and a peripheral bus divided into eight register selects, numbered 0 to 7. Selects 0 to 6 reach external devices, and select 7 is internal. A 16-bit control register chooses, for each external select and separately for reads and writes, whether an access gets one wait state. With no wait state an access takes one bus cycle. With a wait state it takes two, so at a 20 MHz clock the access time rises from 50 ns to 100 ns.

When software enables it, an external hold input can stretch an access beyond its programmed length. The block registers each accepted request and drives a one-hot select strobe, read and write strobes, the address and the write data to the peripheral. It tells the core when it may proceed with a single ready signal. The core may present a new request in any cycle in which ready is high, and that request is accepted at the next rising edge. Back-to-back accesses therefore leave no gap.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0, `core_ready` is 1, `bus_rd`, `bus_wr` and every `bus_sel_oh` bit are 0, and `user_out_en` is 0.
- R2: A `cfg_wr` pulse loads all 16 bits of `cfg_wdata` into the control register at the next edge. `cfg_rdata` returns all 16 bits, and `user_out_en` follows bit 15.
- R3: Bit 2n+1 of the control register (n = 0..6) adds one wait state to reads of select n. Such a read holds its strobes for two cycles, and `core_ready` is low in the first of them.
- R4: Bit 2n of the control register (n = 0..6) adds one wait state to writes of select n. The effect matches R3, for writes only.
- R5: An access with no wait state programmed holds its strobes for one cycle, and `core_ready` is high in that cycle (unless R8 applies). Between accesses `core_ready` is high.
- R6: Accesses to select 7 never get a programmed wait state, whatever the register holds.
- R7: While bit 14 is 0, the `pin_wait` input has no effect on the length of any access.
- R8: While bit 14 is 1, `pin_wait` is sampled in the last programmed cycle of an access. This is the first cycle if no wait state is programmed. The access stays in that cycle, with `core_ready` low, until `pin_wait` is low.
- R9: During an access, exactly one `bus_sel_oh` bit (bit = select number) and one of `bus_rd`/`bus_wr` are high. `bus_addr`, `bus_wdata` and the strobes stay stable until the cycle in which `core_ready` is high.
- R10: The wait-state decision and the bit-14 setting are taken when a request is accepted. A register write in the same or a later cycle changes only accesses accepted afterwards.
- R11: A request presented while `core_ready` is high is accepted at that edge, including in the final cycle of a previous access.
- R12: `core_rdata` equals `bus_rdata` while `bus_rd` is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Core requests an access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select 0..7 |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 16 | Write data from core |
| core_ready | output | 1 | Core may proceed / new request accepted |
| core_rdata | output | 16 | Read data to core |
| cfg_wr | input | 1 | Load control register |
| cfg_wdata | input | 16 | Control register write value |
| cfg_rdata | output | 16 | Control register readback |
| pin_wait | input | 1 | External hold input, active high |
| user_out_en | output | 1 | Enable for the user outputs (register bit 15) |
| bus_sel_oh | output | 8 | One-hot select strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 8 | Registered address |
| bus_wdata | output | 16 | Registered write data |
| bus_rdata | input | 16 | Read data from peripheral |

## Verification
A wrong cycle counter, or a wrongly latched wait decision, shows up at `core_ready` in the first cycle of the affected access. Ready is then high one cycle early or low one cycle late, and every later accept edge shifts with it. A bad register decode shows up the first time the affected select and direction are accessed. A lost capture register shows up in the same cycle as a wrong strobe, address or data value. The behavioural model is compared with every output on every clock, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int NUM_SEL     = 8;
    localparam int SEL_W       = $clog2(NUM_SEL);
    localparam int INT_SEL     = NUM_SEL - 1;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 16;
    localparam int CFG_W       = 16;
    localparam int WAIT_EN_BIT = 14;
    localparam int UOUT_BIT    = 15;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_e;

    // Bit index in the control register of the wait request for a select/direction
    function automatic int ws_bit(input int sel, input logic is_read);
        return 2 * sel + (is_read ? 1 : 0);
    endfunction

endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg
    import bwc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_q,
    output logic [NUM_SEL-1:0]  ws_rd_vec,
    output logic [NUM_SEL-1:0]  ws_wr_vec,
    output logic                wait_pin_en,
    output logic                user_out_en
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_wdata;
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_dec
        if (g == INT_SEL) begin : g_int
            assign ws_rd_vec[g] = 1'b0;
            assign ws_wr_vec[g] = 1'b0;
        end else begin : g_ext
            assign ws_rd_vec[g] = cfg_q[ws_bit(g, 1'b1)];
            assign ws_wr_vec[g] = cfg_q[ws_bit(g, 1'b0)];
        end
    end

    assign wait_pin_en = cfg_q[WAIT_EN_BIT];
    assign user_out_en = cfg_q[UOUT_BIT];

    // R2: user output enable tracks bit 15 of the last write
    p_user_out_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (user_out_en == $past(cfg_wdata[UOUT_BIT])));

endmodule

// File: rtl/bwc_wait_seq.sv
module bwc_wait_seq
    import bwc_pkg::*;
#(
    parameter int MAX_WS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic need_ws,
    input  logic wait_en,
    input  logic pin_wait,
    output logic busy,
    output logic ready
);

    localparam int CNT_W = (MAX_WS < 1) ? 1 : $clog2(MAX_WS + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic             wen_q;
    logic             last_cyc;
    logic             hold;
    logic             done;

    assign busy     = (state_q == SEQ_ACTIVE);
    assign last_cyc = (cnt_q == tgt_q);
    assign hold     = wen_q && pin_wait;
    assign done     = busy && last_cyc && !hold;
    assign ready    = !busy || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
            wen_q   <= 1'b0;
        end else if (accept) begin
            state_q <= SEQ_ACTIVE;
            cnt_q   <= '0;
            tgt_q   <= need_ws ? CNT_W'(MAX_WS) : '0;
            wen_q   <= wait_en;
        end else if (done) begin
            state_q <= SEQ_IDLE;
        end else if (busy && !last_cyc) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R7: with the hold input disabled, the last programmed cycle always completes
    p_wait_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && last_cyc && !wen_q) |-> ready);

    // R5: no stall between accesses
    p_idle_ready_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ready);

endmodule

// File: rtl/bwc_bus_drv.sv
module bwc_bus_drv
    import bwc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  bus_req_t            req,
    input  logic                busy,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_SEL-1:0]  bus_sel_oh,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   core_rdata
);

    bus_req_t cap_q;

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (accept)
            cap_q <= req;
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_strobe
        assign bus_sel_oh[g] = busy && (cap_q.sel == SEL_W'(g));
    end

    assign bus_rd     = busy && !cap_q.we;
    assign bus_wr     = busy && cap_q.we;
    assign bus_addr   = cap_q.addr;
    assign bus_wdata  = cap_q.wdata;
    assign core_rdata = bus_rd ? bus_rdata : '0;

    // R9: one select strobe at most, exactly one while active
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_sel_oh) && (busy == (bus_sel_oh != '0)));

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int MAX_WS = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_req,
    input  logic                  acc_we,
    input  logic [SEL_W-1:0]      acc_sel,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [DATA_W-1:0]     acc_wdata,
    output logic                  core_ready,
    output logic [DATA_W-1:0]     core_rdata,
    input  logic                  cfg_wr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [CFG_W-1:0]      cfg_rdata,
    input  logic                  pin_wait,
    output logic                  user_out_en,
    output logic [NUM_SEL-1:0]    bus_sel_oh,
    output logic                  bus_rd,
    output logic                  bus_wr,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W-1:0]     bus_rdata
);

    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_SEL-1:0] ws_rd_vec;
    logic [NUM_SEL-1:0] ws_wr_vec;
    logic               wait_pin_en;
    logic               need_ws;
    logic               accept;
    logic               busy;
    bus_req_t           req;

    assign req.sel   = acc_sel;
    assign req.we    = acc_we;
    assign req.addr  = acc_addr;
    assign req.wdata = acc_wdata;

    assign need_ws   = acc_we ? ws_wr_vec[acc_sel] : ws_rd_vec[acc_sel];
    assign accept    = acc_req && core_ready;
    assign cfg_rdata = cfg_q;

    bwc_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_q       (cfg_q),
        .ws_rd_vec   (ws_rd_vec),
        .ws_wr_vec   (ws_wr_vec),
        .wait_pin_en (wait_pin_en),
        .user_out_en (user_out_en)
    );

    bwc_wait_seq #(.MAX_WS(MAX_WS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .need_ws  (need_ws),
        .wait_en  (wait_pin_en),
        .pin_wait (pin_wait),
        .busy     (busy),
        .ready    (core_ready)
    );

    bwc_bus_drv u_drv (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req        (req),
        .busy       (busy),
        .bus_rdata  (bus_rdata),
        .bus_sel_oh (bus_sel_oh),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .core_rdata (core_rdata)
    );

    // R9: peripheral-side outputs frozen while the core is stalled
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !core_ready) |=>
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_sel_oh)
             && $stable(bus_wr)));

    // R6: internal select completes in its first cycle when hold is disabled
    p_int_nows_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && (acc_sel == SEL_W'(INT_SEL)) && !cfg_q[WAIT_EN_BIT]) |=> core_ready);

endmodule

// File: tb/sim_bus_wait_ctrl.sv
module sim_bus_wait_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_req = 1'b0, acc_we = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [7:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        core_ready;
    logic [15:0] core_rdata;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        pin_wait = 1'b0;
    logic        user_out_en;
    logic [7:0]  bus_sel_oh;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = 16'h0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    bus_wait_ctrl u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic [15:0] m_cfg;
    bit          m_busy;
    int          m_left;
    bit          m_hold_en;
    int          m_sel;
    bit          m_we;
    logic [7:0]  m_addr;
    logic [15:0] m_wd;

    function automatic bit m_ready();
        if (!m_busy) return 1'b1;
        if (m_left > 0) return 1'b0;
        return !(m_hold_en && pin_wait);
    endfunction

    function automatic int prog_ws(input logic [15:0] c, input int sel, input bit we);
        if (sel == 7) return 0;
        return we ? int'(c[2*sel]) : int'(c[2*sel+1]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = '0; m_busy = 0; m_left = 0; m_hold_en = 0;
            m_sel = 0; m_we = 0; m_addr = '0; m_wd = '0;
        end else begin
            bit rdy;
            rdy = m_ready();
            if (m_busy) begin
                if (m_left > 0) m_left--;
                else if (rdy) m_busy = 0;
            end
            if (acc_req && rdy) begin
                m_busy = 1; m_sel = int'(acc_sel); m_we = acc_we;
                m_addr = acc_addr; m_wd = acc_wdata;
                m_left = prog_ws(m_cfg, m_sel, m_we);
                m_hold_en = m_cfg[14];
            end
            if (cfg_wr) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all(input string rtag);
        chk({rtag, " ready"}, 32'(core_ready), 32'(m_ready()));
        chk("R9 sel_oh", 32'(bus_sel_oh), m_busy ? (32'd1 << m_sel) : 32'd0);
        chk("R9 rd", 32'(bus_rd), 32'(m_busy && !m_we));
        chk("R9 wr", 32'(bus_wr), 32'(m_busy && m_we));
        chk("R9 addr", 32'(bus_addr), 32'(m_addr));
        chk("R9 wdata", 32'(bus_wdata), 32'(m_wd));
        chk("R2 cfg_rdata", 32'(cfg_rdata), 32'(m_cfg));
        chk("R2 user_out_en", 32'(user_out_en), 32'(m_cfg[15]));
        chk("R12 rdata", 32'(core_rdata), (m_busy && !m_we) ? 32'(bus_rdata) : 32'd0);
    endtask

    // drive one cycle at the falling edge, then compare against the model
    task automatic step(input bit req, input bit we, input int sel,
                        input bit cw, input logic [15:0] cv, input bit pw,
                        input string rtag);
        @(negedge clk);
        acc_req = req; acc_we = we; acc_sel = 3'(sel);
        acc_addr = 8'(sel * 17 + 3); acc_wdata = 16'(16'hA500 + sel);
        cfg_wr = cw; cfg_wdata = cv; pin_wait = pw;
        bus_rdata = 16'(16'h3C00 + sel * 5);
        #1;
        compare_all(rtag);
    endtask

    task automatic idle(input int n, input bit pw, input string rtag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, pw, rtag);
    endtask

    task automatic one(input bit we, input int sel, input string rtag);
        step(1, we, sel, 0, '0, 0, rtag);
        idle(3, 0, rtag);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset values
        chk("R1 cfg", 32'(cfg_rdata), 32'd0);
        chk("R1 ready", 32'(core_ready), 32'd1);
        chk("R1 strobes", 32'({bus_sel_oh, bus_rd, bus_wr}), 32'd0);
        chk("R1 uout", 32'(user_out_en), 32'd0);

        // R5: all selects, no wait states programmed
        for (int s = 0; s < 8; s++) begin
            one(0, s, "R5");
            one(1, s, "R5");
        end
        // R2: register write and readback
        step(0, 0, 0, 1, 16'hFFFF, 0, "R2");
        idle(1, 0, "R2");
        step(0, 0, 0, 1, 16'h8000, 0, "R2");
        idle(1, 0, "R2");
        // R3: read wait states only (odd bits)
        step(0, 0, 0, 1, 16'h2AAA, 0, "R3");
        for (int s = 0; s < 8; s++) begin
            one(0, s, "R3");
            one(1, s, "R3");
        end
        // R4: write wait states only (even bits)
        step(0, 0, 0, 1, 16'h1555, 0, "R4");
        for (int s = 0; s < 8; s++) begin
            one(1, s, "R4");
            one(0, s, "R4");
        end
        // R6: all wait bits set, internal select stays single-cycle
        step(0, 0, 0, 1, 16'h3FFF, 0, "R6");
        one(0, 7, "R6");
        one(1, 7, "R6");
        // R7: hold input high but disabled
        step(1, 0, 2, 0, '0, 1, "R7");
        idle(3, 1, "R7");
        step(1, 1, 7, 0, '0, 1, "R7");
        idle(2, 1, "R7");
        // R8: hold enabled, with and without programmed wait state
        step(0, 0, 0, 1, 16'h4008, 0, "R8");
        step(1, 0, 1, 0, '0, 1, "R8");
        idle(4, 1, "R8");
        idle(2, 0, "R8");
        step(1, 1, 5, 0, '0, 1, "R8");
        idle(3, 1, "R8");
        idle(2, 0, "R8");
        // R10: register change in the accept cycle and mid-access
        step(1, 0, 1, 1, 16'h0000, 1, "R10");
        idle(2, 1, "R10");
        idle(1, 0, "R10");
        step(0, 0, 0, 1, 16'h0008, 0, "R10");
        step(1, 0, 1, 0, '0, 0, "R10");
        step(0, 0, 0, 1, 16'h4000, 1, "R10");
        idle(3, 1, "R10");
        idle(2, 0, "R10");
        // R11: back-to-back requests held high
        step(0, 0, 0, 1, 16'h0C0C, 0, "R11");
        for (int i = 0; i < 12; i++) step(1, i[0], i % 8, 0, '0, 0, "R11");
        idle(3, 0, "R11");
        // mixed random traffic
        for (int i = 0; i < 1500; i++) begin
            bit cw;
            cw = ($urandom % 16) == 0;
            step(($urandom % 3) != 0, 1'($urandom), int'($urandom % 8),
                 cw, 16'($urandom), ($urandom % 4) == 0, "R9");
        end
        pin_wait = 1'b0;
        idle(10, 0, "R8");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule